// File: doc/BRIEF.md
# Next-PC And Branch Unit

This block decides where a 32-bit RISC core fetches next. It holds the program counter in a register and looks at the current instruction word and the two register read values. From these it works out the following PC for all five kinds of control transfer: the two conditional branches, the plain jump, the call, and the jump through a register. Any other instruction advances the PC to the next 4-byte word.

The next PC, a taken flag and a link write port (enable, register index and value) are all produced in the same cycle as the instruction. The register file takes the link write. The PC register loads the next PC on every rising clock edge. A synchronous reset puts the PC at a start address set by a parameter.

Top module: `npc_unit`

## Requirements
- R1: While `rst` is high at a rising edge the PC register loads `START_PC` (default 0x0040_0000). Otherwise it loads the `next_pc` that was presented before that edge.
- R2: An instruction that is not one of the control transfers below gives `next_pc` = `pc` + 4 (modulo 2^32) with `taken` low.
- R3: Branch-if-equal is opcode 6'h04 in bits [31:26]. If `rs_val` equals `rt_val`, `next_pc` = `pc` + 4 + (sign-extended bits [15:0]) × 4 and `taken` is high. If they differ, R2 applies.
- R4: Branch-if-not-equal is opcode 6'h05. It uses the same target as R3 and is taken only when `rs_val` differs from `rt_val`. If they are equal, R2 applies.
- R5: The 16-bit branch offset is sign-extended. This includes the extreme values 16'h8000 (backward by 0x20000 bytes) and 16'h7FFF (forward by 0x1FFFC bytes).
- R6: Jump is opcode 6'h02. `next_pc` = {`pc`[31:28], bits [25:0], 2'b00}, and `taken` is high.
- R7: Call is opcode 6'h03. It uses the same target as R6. In the same cycle it raises `link_we` with `link_val` = `pc` + 4 and `link_idx` = 31.
- R8: Jump-register is opcode 6'h00 with function field bits [5:0] = 6'h08. It gives `next_pc` = `rs_val` with `taken` high. Opcode 6'h00 with any other function value follows R2.
- R9: `link_we` is high only for the call. Branches, jumps and jump-register never raise it. `link_idx` is never 0.
- R10: `taken` is high exactly for jumps, calls, jump-register and branches whose condition holds.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| instr | input | 32 | Instruction word at the current PC |
| rs_val | input | 32 | Value of the first source register |
| rt_val | input | 32 | Value of the second source register |
| pc | output | 32 | Current program counter |
| next_pc | output | 32 | PC to be loaded at the next edge |
| taken | output | 1 | Control transfer redirects the PC |
| link_we | output | 1 | Link register write enable |
| link_idx | output | 5 | Link register index (fixed) |
| link_val | output | 32 | Return address to write |

## Verification
Two functions share a single cycle in a call: the link write of the return address and the redirect of the PC. The bench issues calls from PCs in different upper 4-bit regions. In the cycle of the call it checks that `link_val` holds the old PC plus 4 while `next_pc` already carries the spliced jump target. On the next edge it checks that the PC register took that target. A reset raised in the same cycle as a jump provokes a second overlap, between the jump and the reset. The bench judges it by the PC landing on the start address rather than the jump target.

// File: rtl/npc_pkg.sv
package npc_pkg;
   localparam int unsigned ILEN = 32;
   localparam logic [5:0] OPC_SPECIAL = 6'h00;
   localparam logic [5:0] OPC_JUMP    = 6'h02;
   localparam logic [5:0] OPC_CALL    = 6'h03;
   localparam logic [5:0] OPC_BR_EQ   = 6'h04;
   localparam logic [5:0] OPC_BR_NE   = 6'h05;
   localparam logic [5:0] FN_JREG     = 6'h08;

   typedef enum logic [2:0] {
      CF_SEQ  = 3'd0,
      CF_BEQ  = 3'd1,
      CF_BNE  = 3'd2,
      CF_JMP  = 3'd3,
      CF_CALL = 3'd4,
      CF_JREG = 3'd5
   } cf_kind_t;

   typedef struct packed {
      cf_kind_t    kind;
      logic [15:0] br_off;
      logic [25:0] j_index;
   } cf_decode_t;
endpackage

// File: rtl/npc_decode.sv
module npc_decode
   import npc_pkg::*;
(
   input  logic [ILEN-1:0] instr,
   output cf_decode_t      dec
);
   logic [5:0] opc;
   logic [5:0] fn;

   assign opc = instr[31:26];
   assign fn  = instr[5:0];

   always_comb begin
      dec.br_off  = instr[15:0];
      dec.j_index = instr[25:0];
      unique case (opc)
         OPC_BR_EQ:   dec.kind = CF_BEQ;
         OPC_BR_NE:   dec.kind = CF_BNE;
         OPC_JUMP:    dec.kind = CF_JMP;
         OPC_CALL:    dec.kind = CF_CALL;
         OPC_SPECIAL: dec.kind = (fn == FN_JREG) ? CF_JREG : CF_SEQ;
         default:     dec.kind = CF_SEQ;
      endcase
   end
endmodule

// File: rtl/npc_compare.sv
module npc_compare #(
   parameter int unsigned XLEN    = 32,
   parameter bit          XOR_TREE = 1'b1
) (
   input  logic [XLEN-1:0] a,
   input  logic [XLEN-1:0] b,
   output logic            same
);
   generate
      if (XOR_TREE) begin : g_xor
         logic [XLEN-1:0] diff;
         assign diff = a ^ b;
         assign same = ~(|diff);
      end else begin : g_eq
         assign same = (a == b);
      end
   endgenerate
endmodule

// File: rtl/npc_targets.sv
module npc_targets #(
   parameter int unsigned XLEN = 32
) (
   input  logic [XLEN-1:0] pc,
   input  logic [15:0]     br_off,
   input  logic [25:0]     j_index,
   output logic [XLEN-1:0] seq_pc,
   output logic [XLEN-1:0] br_pc,
   output logic [XLEN-1:0] jmp_pc
);
   localparam int unsigned EXT_W   = XLEN - 18;
   localparam int unsigned KEEP_LO = 28;

   logic [XLEN-1:0] off_bytes;

   assign seq_pc    = pc + XLEN'(4);
   assign off_bytes = {{EXT_W{br_off[15]}}, br_off, 2'b00};
   assign br_pc     = seq_pc + off_bytes;
   assign jmp_pc    = {pc[XLEN-1:KEEP_LO], j_index, 2'b00};
endmodule

// File: rtl/npc_select.sv
module npc_select
   import npc_pkg::*;
#(
   parameter int unsigned XLEN = 32
) (
   input  cf_kind_t        kind,
   input  logic            same,
   input  logic [XLEN-1:0] seq_pc,
   input  logic [XLEN-1:0] br_pc,
   input  logic [XLEN-1:0] jmp_pc,
   input  logic [XLEN-1:0] reg_pc,
   output logic [XLEN-1:0] next_pc,
   output logic            taken,
   output logic            link_we
);
   always_comb begin
      next_pc = seq_pc;
      taken   = 1'b0;
      link_we = 1'b0;
      unique case (kind)
         CF_BEQ: if (same) begin
            next_pc = br_pc;
            taken   = 1'b1;
         end
         CF_BNE: if (!same) begin
            next_pc = br_pc;
            taken   = 1'b1;
         end
         CF_JMP: begin
            next_pc = jmp_pc;
            taken   = 1'b1;
         end
         CF_CALL: begin
            next_pc = jmp_pc;
            taken   = 1'b1;
            link_we = 1'b1;
         end
         CF_JREG: begin
            next_pc = reg_pc;
            taken   = 1'b1;
         end
         default: ;
      endcase
   end
endmodule

// File: rtl/npc_unit.sv
module npc_unit
   import npc_pkg::*;
#(
   parameter int unsigned XLEN      = 32,
   parameter int unsigned REG_IDX_W = 5,
   parameter int unsigned LINK_REG  = 31,
   parameter logic [XLEN-1:0] START_PC = 32'h0040_0000,
   parameter bit          XOR_TREE  = 1'b1
) (
   input  logic                 clk,
   input  logic                 rst,
   input  logic [ILEN-1:0]      instr,
   input  logic [XLEN-1:0]      rs_val,
   input  logic [XLEN-1:0]      rt_val,
   output logic [XLEN-1:0]      pc,
   output logic [XLEN-1:0]      next_pc,
   output logic                 taken,
   output logic                 link_we,
   output logic [REG_IDX_W-1:0] link_idx,
   output logic [XLEN-1:0]      link_val
);
   localparam int unsigned REG_COUNT = 1 << REG_IDX_W;

   generate
      if (XLEN < 32) begin : g_bad_xlen
         $error("npc_unit: XLEN must be at least 32");
      end
      if (LINK_REG == 0 || LINK_REG >= REG_COUNT) begin : g_bad_link
         $error("npc_unit: LINK_REG must be nonzero and fit REG_IDX_W");
      end
      if (START_PC[1:0] != 2'b00) begin : g_bad_start
         $error("npc_unit: START_PC must be word aligned");
      end
   endgenerate

   cf_decode_t      dec;
   logic            same;
   logic [XLEN-1:0] seq_pc;
   logic [XLEN-1:0] br_pc;
   logic [XLEN-1:0] jmp_pc;

   npc_decode u_dec (
      .instr (instr),
      .dec   (dec)
   );

   npc_compare #(.XLEN(XLEN), .XOR_TREE(XOR_TREE)) u_cmp (
      .a    (rs_val),
      .b    (rt_val),
      .same (same)
   );

   npc_targets #(.XLEN(XLEN)) u_tgt (
      .pc      (pc),
      .br_off  (dec.br_off),
      .j_index (dec.j_index),
      .seq_pc  (seq_pc),
      .br_pc   (br_pc),
      .jmp_pc  (jmp_pc)
   );

   npc_select #(.XLEN(XLEN)) u_sel (
      .kind    (dec.kind),
      .same    (same),
      .seq_pc  (seq_pc),
      .br_pc   (br_pc),
      .jmp_pc  (jmp_pc),
      .reg_pc  (rs_val),
      .next_pc (next_pc),
      .taken   (taken),
      .link_we (link_we)
   );

   assign link_idx = REG_IDX_W'(LINK_REG);
   assign link_val = seq_pc;

   always_ff @(posedge clk) begin
      if (rst) pc <= START_PC;
      else     pc <= next_pc;
   end
endmodule

// File: rtl/npc_unit_chk.sv
module npc_unit_chk
   import npc_pkg::*;
#(
   parameter int unsigned XLEN      = 32,
   parameter int unsigned REG_IDX_W = 5,
   parameter logic [XLEN-1:0] START_PC = 32'h0040_0000
) (
   input logic                 clk,
   input logic                 rst,
   input logic [ILEN-1:0]      instr,
   input logic [XLEN-1:0]      rs_val,
   input logic [XLEN-1:0]      rt_val,
   input logic [XLEN-1:0]      pc,
   input logic [XLEN-1:0]      next_pc,
   input logic                 taken,
   input logic                 link_we,
   input logic [REG_IDX_W-1:0] link_idx,
   input logic [XLEN-1:0]      link_val
);
   logic [5:0] opc;
   assign opc = instr[31:26];

   // R1
   reset_start_chk: assert property (@(posedge clk) rst |=> pc == START_PC);

   // R1
   pc_follow_chk: assert property (@(posedge clk) disable iff (rst)
      !rst |=> pc == $past(next_pc));

   // R2
   seq_step_chk: assert property (@(posedge clk) disable iff (rst)
      !taken |-> next_pc == pc + XLEN'(4));

   // R3
   beq_hold_chk: assert property (@(posedge clk) disable iff (rst)
      (opc == OPC_BR_EQ && rs_val != rt_val) |-> !taken);

   // R4
   bne_hold_chk: assert property (@(posedge clk) disable iff (rst)
      (opc == OPC_BR_NE && rs_val == rt_val) |-> !taken);

   // R6
   jump_region_chk: assert property (@(posedge clk) disable iff (rst)
      (opc == OPC_JUMP || opc == OPC_CALL) |-> (taken && next_pc[XLEN-1:28] == pc[XLEN-1:28]));

   // R9
   link_target_chk: assert property (@(posedge clk) disable iff (rst)
      link_we |-> (link_idx != '0 && link_val == pc + XLEN'(4) && opc == OPC_CALL));
endmodule

bind npc_unit npc_unit_chk #(
   .XLEN(XLEN), .REG_IDX_W(REG_IDX_W), .START_PC(START_PC)
) u_chk (
   .clk(clk), .rst(rst), .instr(instr), .rs_val(rs_val), .rt_val(rt_val),
   .pc(pc), .next_pc(next_pc), .taken(taken), .link_we(link_we),
   .link_idx(link_idx), .link_val(link_val)
);

// File: tb/npc_unit_tb.sv
`timescale 1ns/1ps
module npc_unit_tb_top;
   localparam logic [31:0] START = 32'h0040_0000;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [31:0] instr = 32'h0;
   logic [31:0] rs_val = 32'h0;
   logic [31:0] rt_val = 32'h0;
   logic [31:0] pc, next_pc, link_val;
   logic        taken, link_we;
   logic [4:0]  link_idx;

   int checks = 0;
   int errors = 0;
   logic [31:0] model_pc;
   bit done = 1'b0;

   typedef struct {
      logic [31:0] e_pc;
      logic [31:0] e_next;
      logic        e_tk;
      logic        e_we;
      logic [31:0] e_lv;
      string       tag;
   } exp_t;
   exp_t sb[$];

   always #2.5 clk = ~clk;

   npc_unit dut_i (
      .clk(clk), .rst(rst), .instr(instr), .rs_val(rs_val), .rt_val(rt_val),
      .pc(pc), .next_pc(next_pc), .taken(taken), .link_we(link_we),
      .link_idx(link_idx), .link_val(link_val)
   );

   function automatic logic [31:0] mk_br(input logic [5:0] op, input logic [15:0] off);
      return {op, 5'd3, 5'd4, off};
   endfunction
   function automatic logic [31:0] mk_j(input logic [5:0] op, input logic [25:0] idx);
      return {op, idx};
   endfunction
   function automatic logic [31:0] mk_special(input logic [5:0] fn);
      return {6'h00, 5'd9, 15'd0, fn};
   endfunction

   task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
      end
   endtask

   // Reference computed from the requirement text
   task automatic step(input logic [31:0] ins, input logic [31:0] a, input logic [31:0] b, input string tag);
      exp_t e;
      logic [31:0] seq;
      logic [31:0] brt;
      seq = model_pc + 32'd4;
      brt = seq + {{14{ins[15]}}, ins[15:0], 2'b00};
      e.e_pc = model_pc; e.e_next = seq; e.e_tk = 1'b0; e.e_we = 1'b0; e.e_lv = seq; e.tag = tag;
      case (ins[31:26])
         6'h04: if (a == b) begin e.e_next = brt; e.e_tk = 1'b1; end
         6'h05: if (a != b) begin e.e_next = brt; e.e_tk = 1'b1; end
         6'h02: begin e.e_next = {model_pc[31:28], ins[25:0], 2'b00}; e.e_tk = 1'b1; end
         6'h03: begin e.e_next = {model_pc[31:28], ins[25:0], 2'b00}; e.e_tk = 1'b1; e.e_we = 1'b1; end
         6'h00: if (ins[5:0] == 6'h08) begin e.e_next = a; e.e_tk = 1'b1; end
         default: ;
      endcase
      @(negedge clk);
      instr = ins; rs_val = a; rt_val = b;
      sb.push_back(e);
      model_pc = e.e_next;
   endtask

   // R1: reset, applied together with a jump after the first pass
   task automatic do_reset(input int cycles, input logic [31:0] ins, input string tag);
      @(negedge clk);
      rst = 1'b1; instr = ins;
      repeat (cycles) @(negedge clk);
      #1;
      chk(tag, "pc after reset", pc, START);
      rst = 1'b0; instr = 32'h0;
      model_pc = START + 32'd4;
   endtask

   initial begin : monitor
      exp_t e;
      forever begin
         @(negedge clk);
         #2;
         while (sb.size() > 0) begin
            e = sb.pop_front();
            chk(e.tag, "pc", pc, e.e_pc);
            chk(e.tag, "next_pc", next_pc, e.e_next);
            chk({e.tag, "/R10"}, "taken", {31'd0, taken}, {31'd0, e.e_tk});
            chk({e.tag, "/R9"}, "link_we", {31'd0, link_we}, {31'd0, e.e_we});
            chk({e.tag, "/R9"}, "link_idx", {27'd0, link_idx}, 32'd31);
            if (e.e_we) chk({e.tag, "/R7"}, "link_val", link_val, e.e_lv);
         end
      end
   end

   initial begin : watchdog
      #500000;
      if (!done) begin
         errors++; checks++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin : driver
      model_pc = START;
      do_reset(3, 32'h0, "R1 initial");
      step(32'h0000_0000, 32'h0, 32'h0, "R2 nop");
      step(32'h2108_0004, 32'h1, 32'h2, "R2 other opcode");
      step(mk_br(6'h04, 16'h0003), 32'h55, 32'h55, "R3 beq taken fwd");
      step(mk_br(6'h04, 16'h0003), 32'h55, 32'h56, "R3 beq not taken");
      step(mk_br(6'h05, 16'hFFFC), 32'h1, 32'h2, "R4 bne taken back R5");
      step(mk_br(6'h05, 16'hFFFC), 32'h7, 32'h7, "R4 bne not taken");
      step(mk_br(6'h04, 16'h8000), 32'h0, 32'h0, "R5 min offset");
      step(mk_br(6'h04, 16'h7FFF), 32'h0, 32'h0, "R5 max offset");
      step(mk_j(6'h03, 26'h0012345), 32'h0, 32'h0, "R7 call low region");
      step(mk_special(6'h08), 32'hA000_1000, 32'h0, "R8 jreg");
      step(mk_special(6'h09), 32'h1234_5678, 32'h0, "R8 other funct");
      step(mk_j(6'h02, 26'h3FF_FFFF), 32'h0, 32'h0, "R6 jump keeps top bits");
      step(32'h0000_0000, 32'h0, 32'h0, "R2 carry into top bits");
      step(mk_j(6'h03, 26'h000_0001), 32'h9, 32'h9, "R7 call high region");
      step(mk_br(6'h05, 16'h0010), 32'hFFFF_FFFF, 32'h7FFF_FFFF, "R4 bne msb differs");
      step(mk_special(6'h08), 32'h0000_0100, 32'h0, "R8 jreg low");
      do_reset(1, mk_j(6'h02, 26'h0000_100), "R1 reset beats jump");
      step(mk_j(6'h03, 26'h0000_040), 32'h0, 32'h0, "R7 call after reset");
      step(32'h0000_0000, 32'h0, 32'h0, "R2 after call");
      @(negedge clk);
      @(negedge clk);
      #3;
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule